// File: doc/BRIEF.md
# I2C Target Controller with Transmit Page and Receive FIFO

This block is an I2C bus target that answers to any one of several programmable 7-bit addresses. Each address slot has its own enable bit. When a host on the bus addresses the block, it acknowledges, reports which slot matched and whether the transfer is a read or a write. Write data from the bus is collected in a small receive FIFO. Read data is served from a transmit page that local logic preloads.

The local side of the block is a set of plain signals. It consists of the address and enable inputs, a byte write port into the transmit page, a pop port on the receive FIFO, a programmable refill threshold, and six sticky event flags. Each flag is cleared by writing a one to it. SCL and SDA arrive already synchronized to `clk_i`. SDA is driven open-drain: `sda_oe_o` high pulls the line low. Every SCL phase must last several `clk_i` cycles, because the controller reacts to a bus edge one cycle after it sees it.

Top module: `i2c_target_paged`

## Requirements
- R1: A START condition (SDA falls while SCL is high, also as a repeated START) sets flag bit 0 (start), and raises `bus_o` and `busy_o`.
- R2: After START the block shifts in seven address bits MSB first, then the direction bit, and compares the address with every enabled slot. On a hit it drives ACK and sets `match_idx_o` to the lowest matching slot. It sets `mode_o` to the direction bit (1 = read, the block transmits), sets flag bit 1 (address match) and clears `busy_o`.
- R3: An address that matches no enabled slot is not acknowledged and sets no match flag. The rest of the transfer is ignored until the next START or STOP, and nothing is stored in the receive FIFO.
- R4: A STOP condition (SDA rises while SCL is high) returns the block to idle and clears `bus_o` and `busy_o`. While `bus_o` is low, SDA is never driven.
- R5: In a read, each byte is sent MSB first. The first bit is put on SDA while SCL is low after the acknowledge, and each later bit after an SCL falling edge. The block changes SDA only while SCL is low.
- R6: After the eighth bit the block releases SDA. It samples the host's acknowledge on the ninth SCL rising edge, then sets flag bit 2 (transmit done) and clears `busy_o`.
- R7: A sampled NACK sets flag bit 3 (NACK). The block then leaves SDA alone until the next START or STOP, and the NACKed byte stays in the transmit page.
- R8: In a write, `busy_o` rises on the first SCL rising edge of a byte and bits are taken MSB first. A complete byte is pushed into the receive FIFO and acknowledged, and `busy_o` clears. `rx_data_o` shows the oldest byte and `rx_rd_i` pops it.
- R9: With 8 bytes already in the receive FIFO, a further byte is dropped and answered with NACK, and flag bit 4 (FIFO full) is set. The FIFO keeps its 8 bytes in order.
- R10: Each acknowledged byte is removed from the transmit page. Flag bit 5 (threshold) is set when that removal leaves exactly `tx_thresh_i` bytes. A read from an empty page sends 0xFF.
- R11: A `tx_wr_i` pulse is accepted only while `busy_o` is low and the page is not full. An accepted write stores `tx_data_i` and holds `busy_o` high in the next cycle. A write while `busy_o` is high is ignored.
- R12: Flags stay set until a one is written to the matching bit of `irq_clr_i`. A set in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized SCL |
| sda_i | input | 1 | Synchronized SDA |
| sda_oe_o | output | 1 | Pull SDA low when high |
| tgt_en_i | input | N_TGT | Enable per address slot |
| tgt_addr_i | input | 7*N_TGT | Slot addresses, slot 0 in the low bits |
| tx_thresh_i | input | clog2(PAGE_DEPTH+1) | Refill threshold level |
| tx_wr_i | input | 1 | Store tx_data_i in the transmit page |
| tx_data_i | input | 8 | Transmit byte |
| rx_rd_i | input | 1 | Pop the receive FIFO |
| rx_data_o | output | 8 | Oldest received byte |
| rx_count_o | output | clog2(RXF_DEPTH+1) | Bytes in the receive FIFO |
| irq_clr_i | input | 6 | Write-one-to-clear for the flags |
| irq_o | output | 6 | Sticky flags: start, match, done, NACK, full, threshold |
| bus_o | output | 1 | Bus active between START and STOP |
| busy_o | output | 1 | Byte or address phase in progress, or write pending |
| mode_o | output | 1 | 1 when the block transmits |
| match_idx_o | output | clog2(N_TGT) | Slot that matched |

## Verification
The local transmit-page write and the busy state can meet in one cycle. The write that is accepted raises `busy_o`, and a second write held on the very next cycle lands on that busy state. The bench provokes this by keeping `tx_wr_i` high for two consecutive cycles with different data. It then judges the result purely at the bus: the following read must return the first byte, then the next byte written after the busy cycle, and the rejected byte must never appear. A read past the end of the page must return 0xFF.

// File: rtl/i2c_tp_pkg.sv
package i2c_tp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK_WAIT, ST_ACK_DRV,
    ST_RX_BIT, ST_TX_BIT, ST_TX_ACK, ST_IGNORE
  } eng_state_e;

  localparam int unsigned IRQ_W      = 6;
  localparam int unsigned IRQ_START  = 0;
  localparam int unsigned IRQ_AMATCH = 1;
  localparam int unsigned IRQ_TXDONE = 2;
  localparam int unsigned IRQ_NACK   = 3;
  localparam int unsigned IRQ_FULL   = 4;
  localparam int unsigned IRQ_THRESH = 5;
endpackage

// File: rtl/i2c_tp_edge.sv
module i2c_tp_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_tp_fifo.sv
module i2c_tp_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign rdata_o = mem_q[rptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wptr_q] <= wdata_i;
        wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + AW'(1);
      end
      if (do_pop) rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + AW'(1);
      if (do_push && !do_pop) cnt_q <= cnt_q + CW'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/i2c_tp_match.sv
module i2c_tp_match #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic [6:0]     key_i,
  input  logic [N*7-1:0] addr_i,
  input  logic [N-1:0]   en_i,
  output logic           hit_o,
  output logic [IW-1:0]  idx_o
);
  logic [N-1:0] hit_vec;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = en_i[g] && (addr_i[g*7 +: 7] == key_i);
  end

  // lowest slot wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/i2c_target_paged.sv
module i2c_target_paged
  import i2c_tp_pkg::*;
#(
  parameter int unsigned N_TGT      = 4,
  parameter int unsigned PAGE_DEPTH = 8,
  parameter int unsigned RXF_DEPTH  = 8,
  localparam int unsigned IW  = (N_TGT > 1) ? $clog2(N_TGT) : 1,
  localparam int unsigned TCW = $clog2(PAGE_DEPTH + 1),
  localparam int unsigned RCW = $clog2(RXF_DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [N_TGT-1:0]   tgt_en_i,
  input  logic [N_TGT*7-1:0] tgt_addr_i,
  input  logic [TCW-1:0]     tx_thresh_i,
  input  logic               tx_wr_i,
  input  logic [7:0]         tx_data_i,
  input  logic               rx_rd_i,
  output logic [7:0]         rx_data_o,
  output logic [RCW-1:0]     rx_count_o,
  input  logic [IRQ_W-1:0]   irq_clr_i,
  output logic [IRQ_W-1:0]   irq_o,
  output logic               bus_o,
  output logic               busy_o,
  output logic               mode_o,
  output logic [IW-1:0]      match_idx_o
);
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic hit;
  logic [IW-1:0] hit_idx;

  eng_state_e st_q;
  logic [6:0] sr_q;
  logic [2:0] cnt_q;
  logic [7:0] tx_sr_q;
  logic ack_drv_q, ack_ok_q, mode_q, bus_q, eng_busy_q, wr_hold_q;
  logic [IW-1:0] idx_q;
  logic [IRQ_W-1:0] irq_q;

  logic rx_push, rx_full, rx_empty;
  logic tx_push, tx_pop, tx_full, tx_empty, thresh_hit;
  logic [7:0] tx_rdata, tx_head;
  logic [TCW-1:0] tx_count;

  i2c_tp_edge u_edge (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  i2c_tp_match #(.N(N_TGT), .IW(IW)) u_match (
    .key_i(sr_q), .addr_i(tgt_addr_i), .en_i(tgt_en_i),
    .hit_o(hit), .idx_o(hit_idx)
  );

  i2c_tp_fifo #(.DW(8), .DEPTH(RXF_DEPTH)) u_rxf (
    .clk_i, .rst_ni,
    .push_i(rx_push), .wdata_i({sr_q, sda_i}),
    .pop_i(rx_rd_i), .rdata_o(rx_data_o),
    .count_o(rx_count_o), .full_o(rx_full), .empty_o(rx_empty)
  );

  i2c_tp_fifo #(.DW(8), .DEPTH(PAGE_DEPTH)) u_page (
    .clk_i, .rst_ni,
    .push_i(tx_push), .wdata_i(tx_data_i),
    .pop_i(tx_pop), .rdata_o(tx_rdata),
    .count_o(tx_count), .full_o(tx_full), .empty_o(tx_empty)
  );

  assign busy_o  = eng_busy_q | wr_hold_q;
  assign tx_push = tx_wr_i & ~busy_o & ~tx_full;
  assign tx_head = tx_empty ? 8'hFF : tx_rdata;
  assign rx_push = (st_q == ST_RX_BIT) && scl_rise && (cnt_q == 3'd7) && !rx_full;
  assign tx_pop  = (st_q == ST_TX_ACK) && scl_rise && !sda_i && !tx_empty;
  assign thresh_hit = tx_pop && ((tx_count - TCW'(1)) == tx_thresh_i);

  assign sda_oe_o = ((st_q == ST_TX_BIT) && !tx_sr_q[7]) ||
                    ((st_q == ST_ACK_DRV) && ack_drv_q);
  assign irq_o       = irq_q;
  assign bus_o       = bus_q;
  assign mode_o      = mode_q;
  assign match_idx_o = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      sr_q       <= '0;
      cnt_q      <= '0;
      tx_sr_q    <= 8'hFF;
      ack_drv_q  <= 1'b0;
      ack_ok_q   <= 1'b0;
      mode_q     <= 1'b0;
      bus_q      <= 1'b0;
      eng_busy_q <= 1'b0;
      wr_hold_q  <= 1'b0;
      idx_q      <= '0;
      irq_q      <= '0;
    end else begin
      irq_q     <= irq_q & ~irq_clr_i;
      wr_hold_q <= tx_push;
      if (stop_ev) begin
        st_q       <= ST_IDLE;
        bus_q      <= 1'b0;
        eng_busy_q <= 1'b0;
      end else if (start_ev) begin
        st_q       <= ST_ADDR;
        cnt_q      <= '0;
        bus_q      <= 1'b1;
        eng_busy_q <= 1'b1;
        irq_q[IRQ_START] <= 1'b1;
      end else begin
        case (st_q)
          ST_ADDR: if (scl_rise) begin
            sr_q  <= {sr_q[5:0], sda_i};
            cnt_q <= cnt_q + 3'd1;
            if (cnt_q == 3'd7) begin
              eng_busy_q <= 1'b0;
              if (hit) begin
                mode_q    <= sda_i;
                idx_q     <= hit_idx;
                ack_drv_q <= 1'b1;
                irq_q[IRQ_AMATCH] <= 1'b1;
                st_q      <= ST_ACK_WAIT;
              end else begin
                st_q <= ST_IGNORE;
              end
            end
          end
          ST_ACK_WAIT: if (scl_fall) st_q <= ST_ACK_DRV;
          ST_ACK_DRV: if (scl_fall) begin
            cnt_q <= '0;
            if (mode_q) begin
              tx_sr_q    <= tx_head;
              eng_busy_q <= 1'b1;
              st_q       <= ST_TX_BIT;
            end else begin
              st_q <= ST_RX_BIT;
            end
          end
          ST_RX_BIT: if (scl_rise) begin
            if (cnt_q == 3'd0) eng_busy_q <= 1'b1;
            sr_q  <= {sr_q[5:0], sda_i};
            cnt_q <= cnt_q + 3'd1;
            if (cnt_q == 3'd7) begin
              eng_busy_q <= 1'b0;
              ack_drv_q  <= !rx_full;
              if (rx_full) irq_q[IRQ_FULL] <= 1'b1;
              st_q <= ST_ACK_WAIT;
            end
          end
          ST_TX_BIT: if (scl_fall) begin
            if (cnt_q == 3'd7) begin
              st_q <= ST_TX_ACK;
            end else begin
              tx_sr_q <= {tx_sr_q[6:0], 1'b1};
              cnt_q   <= cnt_q + 3'd1;
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              ack_ok_q   <= !sda_i;
              eng_busy_q <= 1'b0;
              irq_q[IRQ_TXDONE] <= 1'b1;
              if (sda_i) irq_q[IRQ_NACK] <= 1'b1;
              if (thresh_hit) irq_q[IRQ_THRESH] <= 1'b1;
            end else if (scl_fall) begin
              if (ack_ok_q) begin
                tx_sr_q    <= tx_head;
                eng_busy_q <= 1'b1;
                cnt_q      <= '0;
                st_q       <= ST_TX_BIT;
              end else begin
                st_q <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_target_paged_chk.sv
module i2c_target_paged_chk
  import i2c_tp_pkg::*;
#(
  parameter int unsigned RXF_DEPTH = 8,
  parameter int unsigned RCW       = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_i,
  input logic             sda_oe_o,
  input logic [IRQ_W-1:0] irq_o,
  input logic             bus_o,
  input logic             busy_o,
  input logic [RCW-1:0]   rx_count_o
);
  assert_start_flags_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_o) |-> (irq_o[IRQ_START] && busy_o));

  assert_match_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o[IRQ_AMATCH]) |-> !busy_o);

  assert_idle_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_o |-> !sda_oe_o);

  assert_sda_low_phase_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o[IRQ_TXDONE]) |-> !busy_o);

  assert_nack_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o[IRQ_NACK]) |-> irq_o[IRQ_TXDONE]);

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_count_o <= RCW'(RXF_DEPTH));

  assert_full_at_depth_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o[IRQ_FULL]) |-> (rx_count_o >= RCW'(RXF_DEPTH - 1)));
endmodule

bind i2c_target_paged i2c_target_paged_chk #(.RXF_DEPTH(RXF_DEPTH), .RCW(RCW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .irq_o(irq_o), .bus_o(bus_o), .busy_o(busy_o), .rx_count_o(rx_count_o)
);

// File: tb/sim_i2c_target_paged.sv
`timescale 1ns/1ps
module sim_i2c_target_paged;
  localparam int Q = 12;
  localparam int H = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_low = 1'b0;
  logic sda_oe;
  logic sda_line;
  logic [3:0] tgt_en = 4'b1011;
  logic [27:0] tgt_addr = {7'h7E, 7'h11, 7'h3A, 7'h50};
  logic [3:0] thresh = 4'd1;
  logic tx_wr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic rx_rd = 1'b0;
  logic [7:0] rx_data;
  logic [3:0] rx_count;
  logic [5:0] irq_clr = 6'h00;
  logic [5:0] irq;
  logic bus, busy, mode;
  logic [1:0] midx;

  int n_chk = 0;
  int n_err = 0;
  bit mon_en = 1'b1;
  logic [7:0] rx_exp_q[$];
  logic [7:0] tx_exp_q[$];

  always #2 clk = ~clk;
  assign sda_line = !(host_low || sda_oe);

  i2c_target_paged u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .tgt_en_i(tgt_en), .tgt_addr_i(tgt_addr), .tx_thresh_i(thresh),
    .tx_wr_i(tx_wr), .tx_data_i(tx_data), .rx_rd_i(rx_rd), .rx_data_o(rx_data),
    .rx_count_o(rx_count), .irq_clr_i(irq_clr), .irq_o(irq), .bus_o(bus),
    .busy_o(busy), .mode_o(mode), .match_idx_o(midx)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    host_low = 1'b0; hw(Q); scl = 1'b1; hw(H);
    host_low = 1'b1; hw(H); scl = 1'b0;
  endtask

  task automatic bus_stop();
    hw(Q); host_low = 1'b1; hw(Q); scl = 1'b1; hw(H);
    host_low = 1'b0; hw(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      hw(Q); host_low = !b[i]; hw(Q); scl = 1'b1; hw(H); scl = 1'b0;
    end
    hw(Q); host_low = 1'b0; hw(Q); scl = 1'b1; hw(H/2);
    acked = !sda_line; hw(H/2); scl = 1'b0;
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    host_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      hw(H); scl = 1'b1; hw(H/2); b[i] = sda_line; hw(H/2); scl = 1'b0;
    end
    hw(Q); host_low = ack; hw(Q); scl = 1'b1; hw(H); scl = 1'b0;
    hw(Q); host_low = 1'b0;
  endtask

  // driver: store a page byte, expect it on the bus if accepted
  task automatic page_write(input logic [7:0] d, input bit expect_taken);
    tx_wr = 1'b1; tx_data = d; hw(1); tx_wr = 1'b0;
    if (expect_taken) tx_exp_q.push_back(d);
  endtask

  task automatic read_check(string tag, input bit ack);
    logic [7:0] b;
    logic [7:0] e;
    recv_byte(ack, b);
    e = (tx_exp_q.size() != 0) ? tx_exp_q.pop_front() : 8'hFF;
    chk(tag, b, e);
  endtask

  task automatic clear_irq();
    irq_clr = 6'h3F; hw(1); irq_clr = 6'h00; hw(1);
  endtask

  // monitor: drain receive FIFO against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      rx_rd = 1'b0;
      if (mon_en && rx_count != 0) begin
        if (rx_exp_q.size() == 0) chk("R8 unexpected rx byte", rx_data, -1);
        else chk("R8 rx data order", rx_data, rx_exp_q.pop_front());
        rx_rd = 1'b1;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    bit a;
    hw(5); rst_n = 1'b1; hw(2);
    chk("R12 reset irq", irq, 0);
    chk("R4 reset bus", bus, 0);
    chk("R11 reset busy", busy, 0);
    chk("R4 reset sda", sda_oe, 0);

    // write transfer to slot 1
    bus_start();
    chk("R1 start flag", irq[0], 1);
    chk("R1 bus", bus, 1);
    chk("R1 busy", busy, 1);
    send_byte({7'h3A, 1'b0}, a);
    chk("R2 addr ack slot1", a, 1);
    chk("R2 match idx", midx, 1);
    chk("R2 mode write", mode, 0);
    chk("R2 match flag", irq[1], 1);
    chk("R2 busy cleared", busy, 0);
    foreach (tgt_addr[i]) ;
    rx_exp_q.push_back(8'hA5); send_byte(8'hA5, a); chk("R8 ack 0", a, 1);
    rx_exp_q.push_back(8'h3C); send_byte(8'h3C, a); chk("R8 ack 1", a, 1);
    rx_exp_q.push_back(8'h81); send_byte(8'h81, a); chk("R8 ack 2", a, 1);
    chk("R8 busy after byte", busy, 0);
    bus_stop();
    chk("R4 bus after stop", bus, 0);
    chk("R4 busy after stop", busy, 0);
    hw(10);
    chk("R8 scoreboard drained", rx_exp_q.size(), 0);
    chk("R12 flags held", irq[1:0], 2'b11);
    clear_irq();
    chk("R12 flags cleared", irq, 0);

    // disabled slot and unknown address
    bus_start();
    send_byte({7'h11, 1'b0}, a);
    chk("R3 disabled slot nack", a, 0);
    chk("R3 no match flag", irq[1], 0);
    send_byte(8'h55, a);
    chk("R3 data ignored", a, 0);
    chk("R3 fifo untouched", rx_count, 0);
    bus_start();
    send_byte({7'h22, 1'b0}, a);
    chk("R3 unknown addr nack", a, 0);
    bus_stop();
    clear_irq();

    // fill receive FIFO via slot 0
    mon_en = 1'b0;
    bus_start();
    send_byte({7'h50, 1'b0}, a);
    chk("R2 slot0 ack", a, 1);
    chk("R2 slot0 idx", midx, 0);
    for (int i = 0; i < 9; i++) begin
      send_byte(8'h10 + 8'(i), a);
      chk((i < 8) ? "R9 ack before full" : "R9 nack when full", a, (i < 8) ? 1 : 0);
    end
    chk("R9 full flag", irq[4], 1);
    chk("R9 fifo count", rx_count, 8);
    bus_stop();
    for (int i = 0; i < 8; i++) rx_exp_q.push_back(8'h10 + 8'(i));
    mon_en = 1'b1;
    hw(20);
    chk("R9 eight bytes kept", rx_exp_q.size(), 0);
    clear_irq();

    // transmit page load; second write lands in the busy cycle
    tx_wr = 1'b1; tx_data = 8'hC3; hw(1);
    tx_exp_q.push_back(8'hC3);
    tx_data = 8'h99;
    chk("R11 busy after write", busy, 1);
    hw(1); tx_wr = 1'b0; hw(2);
    chk("R11 busy released", busy, 0);
    page_write(8'h5A, 1'b1); hw(2);
    page_write(8'h0F, 1'b1); hw(2);

    bus_start();
    send_byte({7'h7E, 1'b1}, a);
    chk("R2 read ack slot3", a, 1);
    chk("R2 mode read", mode, 1);
    chk("R2 slot3 idx", midx, 3);
    read_check("R5 byte0 msb first", 1'b1);
    chk("R6 done flag", irq[2], 1);
    chk("R10 no threshold yet", irq[5], 0);
    read_check("R11 ignored write absent", 1'b1);
    chk("R10 threshold at level", irq[5], 1);
    tx_exp_q.push_front(8'h0F);
    read_check("R7 byte2", 1'b0);
    chk("R7 nack flag", irq[3], 1);
    chk("R6 busy after nack", busy, 0);
    hw(Q);
    chk("R7 sda released", sda_oe, 0);
    bus_stop();
    clear_irq();

    // nacked byte still there, then empty page
    bus_start();
    send_byte({7'h50, 1'b1}, a);
    chk("R2 read slot0 ack", a, 1);
    read_check("R7 nacked byte resent", 1'b1);
    read_check("R10 empty page ff", 1'b0);
    bus_stop();
    chk("R4 final bus", bus, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule